// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the slave side of a serial memory port. It watches chip select, serial clock, serial data in and a pause input. It turns the bit stream into commands for a byte-wide array of 16K locations. All four pins reach the block through two-flop synchronisers and are sampled by a fast system clock, so each serial clock edge shows up as a single-cycle event inside the block. The first byte after select falls is the command. Read-type commands stream bytes back on the serial output, which has a separate drive-enable for the pad. Write-type commands become single-cycle request strobes to a protection unit and to a page-write unit.

Array reads use a synchronous memory with one cycle of latency. For each byte the block fetches one location ahead of the output shifter. Array writes send one strobe per received byte, carrying its page-wrapped address. When select rises, the block either commits the whole burst or reports it as incomplete, and the page-write unit then drops it. Write-protection policy and write-cycle timing belong to the neighbouring units. The block only gets a busy flag and the status byte from them.

Top module: `spi_mem_front`

## Requirements
- R1: Both idle clock levels work: low idle (mode 0) and high idle (mode 3). Input bits are taken on rising clock edges and output bits change on falling clock edges. Every field goes most significant bit first.
- R2: A command byte is valid only when its upper four bits are zero. Bit 3 is ignored. Bits 2..0 select the command: 110 set write-enable, 100 clear write-enable, 101 status read, 001 status write, 011 array read, 010 array write.
- R3: After a command byte that is not valid, the output enable stays low for the rest of the selection, and raising select produces no request strobe.
- R4: A status read shifts out `status_in` as byte after byte for as long as the clock keeps running.
- R5: An array read takes a 16-bit address. Address bits 15 and 14 are ignored. The read returns the bytes at consecutive locations and wraps from 3FFFh back to 0000h.
- R6: In an array write, every complete data byte pulses `arr_wr` with its address and data. The address steps only inside its 64-byte page, so the low six bits wrap. When select rises after at least one whole data byte and no stray bits, `wr_commit` pulses.
- R7: A status write made of exactly one data byte pulses `sr_wr` with that byte when select rises.
- R8: A status write or array write that ends with a partial byte, a missing address or a missing data byte pulses `mod_abort` instead of `sr_wr` or `wr_commit`.
- R9: While `busy` is high at the last bit of the command byte, every command except status read is ignored: no strobe and no output drive.
- R10: While the pause input is low, clock edges and data bits are ignored and the output enable is low. Once the pause ends, the transfer continues from the same bit.
- R11: Set and clear write-enable pulse `wen_set` or `wen_clr` when select rises after exactly eight bits. While select is high the output enable is low, and the next selection starts a new command.
- R12: After reset the output enable is low and no strobe is active.
- R13: A final clock rise that reaches the pins together with the rising select is still counted as a bit. Its byte strobe comes out before the end-of-command strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Drive enable for serial data out |
| busy | input | 1 | Write cycle in progress |
| status_in | input | 8 | Status byte to return on a status read |
| mem_rd | output | 1 | Array read strobe |
| mem_addr | output | 14 | Array read address |
| mem_rdata | input | 8 | Array read data, valid one cycle after `mem_rd` |
| wen_set | output | 1 | Set write-enable request |
| wen_clr | output | 1 | Clear write-enable request |
| sr_wr | output | 1 | Status write request |
| sr_data | output | 8 | Status write value |
| arr_wr | output | 1 | Array byte strobe |
| arr_waddr | output | 14 | Array byte address |
| arr_wdata | output | 8 | Array byte data |
| wr_commit | output | 1 | Array burst complete |
| mod_abort | output | 1 | Modify command incomplete, drop it |

## Verification
The two events that can land in the same system cycle are the last serial clock rise, which completes a data byte, and the rising select that ends the command. The bench provokes this by driving both pins high at the same instant on the last bit of an array write, so that both synchronised edges appear together. It then requires, through an ordered scoreboard of request strobes, that the final byte strobe with its page-wrapped address arrives and is followed by the commit. A lost bit would instead show up as an abort or a missing strobe.

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int AW = 14,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  output logic          so,
  output logic          so_oe,
  input  logic          busy,
  input  logic [7:0]    status_in,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          wen_set,
  output logic          wen_clr,
  output logic          sr_wr,
  output logic [7:0]    sr_data,
  output logic          arr_wr,
  output logic [AW-1:0] arr_waddr,
  output logic [7:0]    arr_wdata,
  output logic          wr_commit,
  output logic          mod_abort
);
  typedef enum logic [2:0] {C_NONE, C_WSET, C_WCLR, C_RDST, C_WRST, C_RD, C_WR} cmd_e;

  logic [1:0] cs_sy, sck_sy, si_sy, hold_sy;
  logic sck_q, cs_q, cs_q2, so_en, rd_req, rd_cap;
  logic [5:0] cnt;
  logic [7:0] sh, txb;
  logic [AW-1:0] addr;
  cmd_e cmd;

  wire hold_s = hold_sy[1];
  wire si_s   = si_sy[1];
  wire act    = ~cs_q & hold_s;
  wire rise   = act & sck_sy[1] & ~sck_q;
  wire fall   = act & ~sck_sy[1] & sck_q;
  wire [5:0] cnt_n = (cnt == 6'd63) ? 6'd32 : cnt + 6'd1;
  wire [7:0] sh_n  = {sh[6:0], si_s};
  wire byte_done   = rise & (cnt_n[2:0] == 3'd0);
  wire is_rd       = (cmd == C_RD) | (cmd == C_WR);

  function automatic cmd_e decode(input logic [7:0] b, input logic bsy);
    cmd_e c;
    case (b[2:0])
      3'b110:  c = C_WSET;
      3'b100:  c = C_WCLR;
      3'b101:  c = C_RDST;
      3'b001:  c = C_WRST;
      3'b011:  c = C_RD;
      3'b010:  c = C_WR;
      default: c = C_NONE;
    endcase
    if (b[7:4] != 4'd0 || (bsy && c != C_RDST)) c = C_NONE;
    return c;
  endfunction

  wire cmd_e cmd_n = (rise && cnt == 6'd7) ? decode(sh_n, busy) : cmd;

  assign so_oe    = so_en & hold_s & ~cs_q;
  assign mem_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 2'b11; sck_sy <= 2'b00; si_sy <= 2'b00; hold_sy <= 2'b11;
      sck_q <= 1'b0; cs_q <= 1'b1; cs_q2 <= 1'b1;
    end else begin
      cs_sy <= {cs_sy[0], cs_n}; sck_sy <= {sck_sy[0], sck};
      si_sy <= {si_sy[0], si};   hold_sy <= {hold_sy[0], hold_n};
      sck_q <= sck_sy[1]; cs_q <= cs_sy[1]; cs_q2 <= cs_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sh <= '0; txb <= '0; addr <= '0; cmd <= C_NONE;
      so <= 1'b0; so_en <= 1'b0; rd_req <= 1'b0; rd_cap <= 1'b0; mem_rd <= 1'b0;
      wen_set <= 1'b0; wen_clr <= 1'b0; sr_wr <= 1'b0; sr_data <= '0;
      arr_wr <= 1'b0; arr_waddr <= '0; arr_wdata <= '0;
      wr_commit <= 1'b0; mod_abort <= 1'b0;
    end else begin
      wen_set <= 1'b0; wen_clr <= 1'b0; sr_wr <= 1'b0; arr_wr <= 1'b0;
      wr_commit <= 1'b0; mod_abort <= 1'b0; rd_req <= 1'b0;
      mem_rd <= rd_req;
      rd_cap <= mem_rd;
      if (mem_rd) addr <= addr + AW'(1);
      if (rd_cap) txb <= mem_rdata;
      if (cs_q && !cs_q2) begin
        case (cmd)
          C_WSET: wen_set <= (cnt == 6'd8);
          C_WCLR: wen_clr <= (cnt == 6'd8);
          C_WRST: if (cnt == 6'd16) sr_wr <= 1'b1; else mod_abort <= 1'b1;
          C_WR:   if (cnt >= 6'd32 && cnt[2:0] == 3'd0) wr_commit <= 1'b1;
                  else mod_abort <= 1'b1;
          default: ;
        endcase
      end
      if (cs_q) begin
        cnt <= '0; cmd <= C_NONE; so_en <= 1'b0;
      end else begin
        if (rise) begin
          cnt <= cnt_n;
          sh  <= sh_n;
          cmd <= cmd_n;
          if (is_rd && cnt >= 6'd8 && cnt < 6'd24) addr <= {addr[AW-2:0], si_s};
          if (byte_done) begin
            if (cmd_n == C_RDST) txb <= status_in;
            if (cmd_n == C_RD && cnt_n >= 6'd24) rd_req <= 1'b1;
            if (cmd == C_WRST && cnt_n == 6'd16) sr_data <= sh_n;
            if (cmd == C_WR && cnt_n >= 6'd32) begin
              arr_wr    <= 1'b1;
              arr_wdata <= sh_n;
              arr_waddr <= addr;
              addr[PW-1:0] <= addr[PW-1:0] + PW'(1);
            end
          end
        end
        if (fall && cnt >= 6'd8 && (cmd == C_RDST || cmd == C_RD)) begin
          so    <= txb[~cnt[2:0]];
          so_en <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic hold_n,
  input logic so_oe,
  input logic mem_rd,
  input logic wen_set,
  input logic wen_clr,
  input logic sr_wr,
  input logic arr_wr,
  input logic wr_commit,
  input logic mod_abort
);
  // R11
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4) |-> !so_oe);

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n && !$past(hold_n) && !$past(hold_n, 2) && !$past(hold_n, 3) |-> !so_oe);

  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wen_set, wen_clr, sr_wr, arr_wr, wr_commit, mod_abort}));

  // R6
  end_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit || mod_abort || sr_wr || wen_set || wen_clr) |-> cs_n);

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_oe(so_oe),
  .mem_rd(mem_rd), .wen_set(wen_set), .wen_clr(wen_clr), .sr_wr(sr_wr),
  .arr_wr(arr_wr), .wr_commit(wr_commit), .mod_abort(mod_abort)
);

// File: tb/tb_spi_mem_front.sv
module tb_spi_mem_front;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] status_in = 8'h00, mem_rdata = 8'h00;
  logic so, so_oe, mem_rd, wen_set, wen_clr, sr_wr, arr_wr, wr_commit, mod_abort;
  logic [13:0] mem_addr, arr_waddr;
  logic [7:0] sr_data, arr_wdata;
  int checks = 0, errors = 0;
  logic [24:0] exp_q[$];
  logic [7:0] tx[16], rx[16];
  bit oe_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mem_front dut (.*);

  function automatic logic [7:0] pat(input logic [13:0] a);
    return a[7:0] + 8'(a[13:8]) * 8'd7 + 8'h5A;
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] k, input logic [13:0] a, input logic [7:0] d);
    exp_q.push_back({k, a, d});
  endtask

  always @(negedge clk) begin
    if (rst_n && (wen_set | wen_clr | sr_wr | arr_wr | wr_commit | mod_abort)) begin
      logic [24:0] got, want;
      got = wen_set ? {3'd1, 22'd0} : wen_clr ? {3'd2, 22'd0} :
            sr_wr ? {3'd3, 14'd0, sr_data} : arr_wr ? {3'd4, arr_waddr, arr_wdata} :
            wr_commit ? {3'd5, 22'd0} : {3'd6, 22'd0};
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected strobe", int'(got), 0);
      else begin
        want = exp_q.pop_front();
        chk(got == want, "R6/R7/R8/R11 strobe", int'(got), int'(want));
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int nbits, input bit m3, input int hold_at, input bit together);
    oe_seen = 1'b0;
    sck = m3; wait_n(2);
    cs_n = 1'b0; wait_n(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (m3) sck = 1'b0;
      si = tx[i/8][7 - i%8];
      if (i == hold_at) begin
        wait_n(HALF);
        hold_n = 1'b0; wait_n(6);
        chk(!so_oe, "R10 output released in pause", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
          sck = 1'b1; si = ~si; wait_n(HALF); sck = 1'b0; wait_n(HALF);
        end
        si = tx[i/8][7 - i%8];
        hold_n = 1'b1;
      end
      wait_n(HALF);
      rx[i/8][7 - i%8] = so;
      oe_seen |= so_oe;
      sck = 1'b1;
      if (together && i == nbits - 1) cs_n = 1'b1;
      wait_n(HALF);
      if (!m3) sck = 1'b0;
    end
    wait_n(HALF);
    cs_n = 1'b1; wait_n(4);
    chk(!so_oe, "R11 output released by select", so_oe, 0);
    sck = m3; wait_n(12);
  endtask

  task automatic q_empty(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(5); rst_n = 1'b1; wait_n(5);
    // R12
    chk(!so_oe && !wen_set && !arr_wr && !mod_abort, "R12 reset state", so_oe, 0);

    // R4 R1 status read, mode 0
    status_in = 8'hA5; tx[0] = 8'h05;
    xfer(32, 1'b0, -1, 1'b0);
    for (int b = 1; b < 4; b++) chk(rx[b] == 8'hA5, "R4 status repeat", rx[b], 8'hA5);
    // R2 bit 3 ignored, R1 mode 3
    status_in = 8'h3C; tx[0] = 8'h0D;
    xfer(24, 1'b1, -1, 1'b0);
    chk(rx[1] == 8'h3C && rx[2] == 8'h3C, "R2 R1 status mode3", rx[2], 8'h3C);

    // R5 R10 read, upper address bits ignored, pause in address
    tx[0] = 8'h03; tx[1] = 8'hC0; tx[2] = 8'h05;
    xfer(40, 1'b0, 14, 1'b0);
    chk(rx[3] == pat(14'h0005), "R10 R5 read after pause", rx[3], pat(14'h0005));
    chk(rx[4] == pat(14'h0006), "R5 sequential", rx[4], pat(14'h0006));
    // R5 wrap, mode 3, bit 3 set
    tx[0] = 8'h0B; tx[1] = 8'h3F; tx[2] = 8'hFE;
    xfer(48, 1'b1, -1, 1'b0);
    chk(rx[3] == pat(14'h3FFE), "R5 read top-1", rx[3], pat(14'h3FFE));
    chk(rx[4] == pat(14'h3FFF), "R5 read top", rx[4], pat(14'h3FFF));
    chk(rx[5] == pat(14'h0000), "R5 wrap to zero", rx[5], pat(14'h0000));

    // R6 R13 page wrap, last clock rise together with select
    tx[0] = 8'h02; tx[1] = 8'h01; tx[2] = 8'h3E; tx[3] = 8'h11; tx[4] = 8'h22; tx[5] = 8'h33;
    push(3'd4, 14'h013E, 8'h11); push(3'd4, 14'h013F, 8'h22);
    push(3'd4, 14'h0100, 8'h33); push(3'd5, 14'd0, 8'd0);
    xfer(48, 1'b0, -1, 1'b1);
    q_empty("R13 R6 write burst");

    // R11 enable set and clear
    tx[0] = 8'h06; push(3'd1, 14'd0, 8'd0); xfer(8, 1'b0, -1, 1'b0);
    tx[0] = 8'h04; push(3'd2, 14'd0, 8'd0); xfer(8, 1'b1, -1, 1'b0);
    q_empty("R11 enable requests");

    // R7 status write
    tx[0] = 8'h01; tx[1] = 8'h8C; push(3'd3, 14'd0, 8'h8C); xfer(16, 1'b0, -1, 1'b0);
    q_empty("R7 status write");

    // R8 incomplete modifies
    tx[0] = 8'h01; tx[1] = 8'hF0; push(3'd6, 14'd0, 8'd0); xfer(12, 1'b0, -1, 1'b0);
    tx[0] = 8'h02; tx[1] = 8'h01; tx[2] = 8'h00; push(3'd6, 14'd0, 8'd0); xfer(24, 1'b0, -1, 1'b0);
    tx[3] = 8'hAA; tx[4] = 8'hE0;
    push(3'd4, 14'h0100, 8'hAA); push(3'd6, 14'd0, 8'd0); xfer(35, 1'b0, -1, 1'b0);
    q_empty("R8 incomplete modify");

    // R3 invalid opcodes
    tx[0] = 8'h07; tx[1] = 8'h00; tx[2] = 8'h00;
    xfer(24, 1'b0, -1, 1'b0);
    chk(!oe_seen, "R3 invalid no drive", oe_seen, 0);
    tx[0] = 8'h16; xfer(8, 1'b0, -1, 1'b0);
    tx[0] = 8'h85; xfer(24, 1'b0, -1, 1'b0);
    chk(!oe_seen, "R2 R3 upper bits nonzero", oe_seen, 0);
    q_empty("R3 no strobe");

    // R9 busy
    busy = 1'b1;
    tx[0] = 8'h06; xfer(8, 1'b0, -1, 1'b0);
    tx[0] = 8'h03; tx[1] = 8'h00; tx[2] = 8'h00; xfer(32, 1'b0, -1, 1'b0);
    chk(!oe_seen, "R9 read ignored while busy", oe_seen, 0);
    status_in = 8'h81; tx[0] = 8'h05; xfer(16, 1'b0, -1, 1'b0);
    chk(rx[1] == 8'h81, "R9 status read while busy", rx[1], 8'h81);
    busy = 1'b0;
    q_empty("R9 no strobe while busy");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule